// File: doc/BRIEF.md
# Serial EEPROM Byte Master with Acknowledge Polling

This block is a two-wire bus master that runs two kinds of transaction against a small serial EEPROM: a single-byte write and a single-byte random read. A command arrives as a one-cycle pulse. It carries a read/write select, a 4-bit word address and a write byte. When the transaction ends, the block raises a one-cycle done pulse. Read data, a NACK error flag and a timeout error flag are held until the next command is accepted. The bus pins are open-drain. The block only ever pulls SCL and SDA low, and it reads SDA back. The bus rate is set by `DIV`, the number of clocks in one quarter of an SCL period.

A write never waits a fixed delay for the device. After the write STOP, the master sends probes: START, then the write control byte. It repeats these until the device acknowledges one, and ends each probe with STOP. A read addresses the device for writing and sends the word address, then switches direction with a true repeated START. It sends the read control byte, clocks in one data byte, NACKs that byte and issues STOP. The control byte is the 7-bit device address shifted up one place, with R/W in bit 0.

The sequencer states are:

- IDLE, which accepts a command and goes to START.
- START, which goes to CTRL.
- CTRL sends the write control byte. On ACK it goes to WADDR. On NACK it goes to RETRY_STOP.
- WADDR sends the word address. On ACK it goes to WDATA for a write or RSTART for a read. On NACK it goes to END_STOP.
- WDATA goes to END_STOP.
- RSTART goes to RCTRL.
- RCTRL sends the read control byte. On ACK it goes to RDATA. On NACK it goes to END_STOP.
- RDATA goes to END_STOP.
- RETRY_STOP goes back to START, or to DONE once the attempt limit is reached.
- END_STOP goes to DONE after a read or an error, and to PSTART after a clean write.
- The poll loop runs PSTART, then PCTRL, then PSTOP. PSTOP goes to DONE on ACK or at the limit, and otherwise back to PSTART.
- DONE returns to IDLE.

Top module: `i2c_eeprom_master`

## Requirements
- R1: Every control byte is `{DEV_ADDR, rw}`, with rw=0 for write and rw=1 for read. With DEV_ADDR=0x50 this gives 0xA0 and 0xA1.
- R2: A write sends the following in one transaction with no STOP inside it: START, 0xA0, the word address `{4'b0, cmd_addr}`, the data byte, then STOP. The device then holds the new byte at that address.
- R3: If the first control byte of a command is NACKed, the master issues STOP and restarts from START. It makes at most POLL_MAX attempts in total. If the device acknowledges within them, the command completes normally.
- R4: After a write STOP, the master repeats START plus 0xA0, each probe ended by STOP, until a probe is acknowledged. Done is raised only after that acknowledged probe and its STOP.
- R5: Polling and command-start retries each stop after POLL_MAX NACKed probes. In that case err_timeout=1, err_nack=0, and done is raised.
- R6: A read sends START, 0xA0 and the word address, then exactly one repeated START with no STOP before it, then 0xA1. It then clocks in one byte, which appears on rd_data when done is high.
- R7: The master NACKs the read data byte (SDA released during its ninth clock) and then issues exactly one STOP.
- R8: A NACK on the word address, data byte or read control byte ends the command with one STOP, err_nack=1 and err_timeout=0. There is no retry, no poll, and nothing is written.
- R9: busy is high from the cycle after acceptance through the done cycle. done is a single-cycle pulse. A cmd_valid pulse while busy is ignored: no extra done, and no bus traffic for it.
- R10: During and after reset, SCL and SDA are released, and busy, done, err_nack and err_timeout are 0.
- R11: Every SCL high pulse inside a byte lasts exactly 2*DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command pulse, taken only while idle |
| cmd_read | input | 1 | 1 = random read, 0 = byte write |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_nack | output | 1 | Command ended on a NACKed address, data or read control byte |
| err_timeout | output | 1 | Attempt limit reached |
| rd_data | output | 8 | Byte returned by the last read |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed level of SDA |

## Verification
The bench builds the block with DIV=4 and POLL_MAX=8, against a behavioural EEPROM that stays busy for about 700 clocks after each write. With these values, every write goes through several NACKed probes, and the attempt limit can be reached within a few thousand cycles. The four-bit address space is small enough that two full write-then-read sweeps cover every location with two different patterns. The device model can also NACK the word address, refuse every control byte, or lengthen its write time. This reaches the error, retry and timeout paths.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    typedef enum logic [2:0] {
        OP_START,
        OP_RSTART,
        OP_STOP,
        OP_WRITE,
        OP_READ
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_CTRL,
        S_WADDR,
        S_WDATA,
        S_RSTART,
        S_RCTRL,
        S_RDATA,
        S_RETRY_STOP,
        S_END_STOP,
        S_PSTART,
        S_PCTRL,
        S_PSTOP,
        S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        E_IDLE,
        E_START,
        E_RSTART,
        E_STOP,
        E_BIT
    } phy_state_e;

endpackage

// File: rtl/i2c_eep_tick.sv
module i2c_eep_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick) else $error("tick gap"); // R11

endmodule

// File: rtl/i2c_eep_phy.sv
module i2c_eep_phy
    import i2c_eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    op_valid,
    input  bus_op_e op,
    input  logic [7:0] tx_byte,
    input  logic    send_nack,
    input  logic    sda_in,
    output logic    op_done,
    output logic [7:0] rx_byte,
    output logic    ack_seen,
    output logic    scl_lo,
    output logic    sda_lo,
    output logic    idle
);
    phy_state_e  state;
    logic [1:0]  ph;
    logic [3:0]  bitn;
    logic [7:0]  shreg;
    logic        is_rd;
    logic        nack_q;

    assign rx_byte = shreg;
    assign idle    = (state == E_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= E_IDLE;
            ph       <= '0;
            bitn     <= '0;
            shreg    <= '0;
            is_rd    <= 1'b0;
            nack_q   <= 1'b0;
            scl_lo   <= 1'b0;
            sda_lo   <= 1'b0;
            op_done  <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            op_done <= 1'b0;
            unique case (state)
                E_IDLE: begin
                    if (op_valid) begin
                        ph   <= '0;
                        bitn <= '0;
                        unique case (op)
                            OP_START:  state <= E_START;
                            OP_RSTART: state <= E_RSTART;
                            OP_STOP:   state <= E_STOP;
                            default: begin
                                state  <= E_BIT;
                                is_rd  <= (op == OP_READ);
                                shreg  <= (op == OP_READ) ? 8'hFF : tx_byte;
                                nack_q <= send_nack;
                            end
                        endcase
                    end
                end
                E_START: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        unique case (ph)
                            2'd0: begin
                                sda_lo <= 1'b0;
                                scl_lo <= 1'b0;
                            end
                            2'd1: sda_lo <= 1'b1;
                            default: begin
                                scl_lo  <= 1'b1;
                                op_done <= 1'b1;
                                state   <= E_IDLE;
                            end
                        endcase
                    end
                end
                E_RSTART: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        unique case (ph)
                            2'd0: sda_lo <= 1'b0;
                            2'd1: scl_lo <= 1'b0;
                            2'd2: sda_lo <= 1'b1;
                            default: begin
                                scl_lo  <= 1'b1;
                                op_done <= 1'b1;
                                state   <= E_IDLE;
                            end
                        endcase
                    end
                end
                E_STOP: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        unique case (ph)
                            2'd0: sda_lo <= 1'b1;
                            2'd1: scl_lo <= 1'b0;
                            default: begin
                                sda_lo  <= 1'b0;
                                op_done <= 1'b1;
                                state   <= E_IDLE;
                            end
                        endcase
                    end
                end
                E_BIT: begin
                    if (tick) begin
                        ph <= ph + 1'b1;
                        unique case (ph)
                            2'd0: begin
                                if (bitn == 4'd8) sda_lo <= is_rd ? !nack_q : 1'b0;
                                else              sda_lo <= is_rd ? 1'b0 : !shreg[7];
                            end
                            2'd1: scl_lo <= 1'b0;
                            2'd2: begin
                                if (bitn == 4'd8) ack_seen <= !sda_in;
                                else              shreg    <= {shreg[6:0], sda_in};
                            end
                            default: begin
                                scl_lo <= 1'b1;
                                if (bitn == 4'd8) begin
                                    op_done <= 1'b1;
                                    state   <= E_IDLE;
                                end else begin
                                    bitn <= bitn + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == E_BIT && !scl_lo && !$past(scl_lo)) |-> $stable(sda_lo)) else $error("sda moved with scl high"); // R2

endmodule

// File: rtl/i2c_eep_seq.sv
module i2c_eep_seq
    import i2c_eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int ADDR_W   = 4,
    parameter int POLL_MAX = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              err_nack,
    output logic              err_timeout,
    output logic [7:0]        rd_data,
    output logic              op_valid,
    output bus_op_e           op,
    output logic [7:0]        tx_byte,
    output logic              send_nack,
    input  logic              op_done,
    input  logic              ack_seen,
    input  logic [7:0]        rx_byte
);
    localparam int TW = $clog2(POLL_MAX + 1);
    localparam logic [TW-1:0] TRY_LIM = TW'(POLL_MAX);
    localparam logic [7:0] CTRL_WR = {DEV_ADDR, 1'b0};
    localparam logic [7:0] CTRL_RD = {DEV_ADDR, 1'b1};

    seq_state_e        state, state_n;
    logic              issued;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [TW-1:0]     tries;
    logic              poll_ok;
    logic              limit;

    assign limit = (tries == TRY_LIM);

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:       if (cmd_valid) state_n = S_START;
            S_START:      if (op_done) state_n = S_CTRL;
            S_CTRL:       if (op_done) state_n = ack_seen ? S_WADDR : S_RETRY_STOP;
            S_WADDR:      if (op_done) state_n = !ack_seen ? S_END_STOP : (rd_q ? S_RSTART : S_WDATA);
            S_WDATA:      if (op_done) state_n = S_END_STOP;
            S_RSTART:     if (op_done) state_n = S_RCTRL;
            S_RCTRL:      if (op_done) state_n = ack_seen ? S_RDATA : S_END_STOP;
            S_RDATA:      if (op_done) state_n = S_END_STOP;
            S_RETRY_STOP: if (op_done) state_n = limit ? S_DONE : S_START;
            S_END_STOP:   if (op_done) state_n = (rd_q || err_nack) ? S_DONE : S_PSTART;
            S_PSTART:     if (op_done) state_n = S_PCTRL;
            S_PCTRL:      if (op_done) state_n = S_PSTOP;
            S_PSTOP:      if (op_done) state_n = (poll_ok || limit) ? S_DONE : S_PSTART;
            S_DONE:       state_n = S_IDLE;
            default:      state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        op        = OP_STOP;
        tx_byte   = CTRL_WR;
        send_nack = 1'b0;
        unique case (state)
            S_START, S_PSTART: op = OP_START;
            S_CTRL, S_PCTRL:   op = OP_WRITE;
            S_WADDR: begin
                op      = OP_WRITE;
                tx_byte = {{(8 - ADDR_W){1'b0}}, addr_q};
            end
            S_WDATA: begin
                op      = OP_WRITE;
                tx_byte = wdata_q;
            end
            S_RSTART: op = OP_RSTART;
            S_RCTRL: begin
                op      = OP_WRITE;
                tx_byte = CTRL_RD;
            end
            S_RDATA: begin
                op        = OP_READ;
                send_nack = 1'b1;
            end
            default: op = OP_STOP;
        endcase
    end

    assign op_valid = !issued && (state != S_IDLE) && (state != S_DONE);
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued      <= 1'b0;
            rd_q        <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            tries       <= '0;
            poll_ok     <= 1'b0;
            err_nack    <= 1'b0;
            err_timeout <= 1'b0;
            rd_data     <= '0;
        end else begin
            if (state_n != state) issued <= 1'b0;
            else if (op_valid)    issued <= 1'b1;

            if (state == S_IDLE && cmd_valid) begin
                rd_q        <= cmd_read;
                addr_q      <= cmd_addr;
                wdata_q     <= cmd_wdata;
                tries       <= '0;
                err_nack    <= 1'b0;
                err_timeout <= 1'b0;
            end

            if (op_done) begin
                unique case (state)
                    S_CTRL, S_PCTRL: begin
                        poll_ok <= ack_seen;
                        if (!ack_seen) tries <= tries + 1'b1;
                    end
                    S_WADDR, S_WDATA, S_RCTRL: if (!ack_seen) err_nack <= 1'b1;
                    S_RDATA:      rd_data <= rx_byte;
                    S_RETRY_STOP: if (limit) err_timeout <= 1'b1;
                    S_END_STOP:   tries <= '0;
                    S_PSTOP:      if (!poll_ok && limit) err_timeout <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done)) else $error("busy fell early"); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done too long"); // R9
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(err_nack && err_timeout)) else $error("both errors"); // R8
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tries <= TRY_LIM) else $error("tries overflow"); // R5

endmodule

// File: rtl/i2c_eeprom_master.sv
module i2c_eeprom_master
    import i2c_eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int ADDR_W   = 4,
    parameter int DIV      = 125,
    parameter int POLL_MAX = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              err_nack,
    output logic              err_timeout,
    output logic [7:0]        rd_data,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              sda_in
);
    logic       tick;
    logic       op_valid;
    bus_op_e    op;
    logic [7:0] tx_byte;
    logic       send_nack;
    logic       op_done;
    logic       ack_seen;
    logic [7:0] rx_byte;
    logic       phy_idle;

    i2c_eep_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    i2c_eep_seq #(
        .DEV_ADDR(DEV_ADDR),
        .ADDR_W  (ADDR_W),
        .POLL_MAX(POLL_MAX)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_read   (cmd_read),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .busy       (busy),
        .done       (done),
        .err_nack   (err_nack),
        .err_timeout(err_timeout),
        .rd_data    (rd_data),
        .op_valid   (op_valid),
        .op         (op),
        .tx_byte    (tx_byte),
        .send_nack  (send_nack),
        .op_done    (op_done),
        .ack_seen   (ack_seen),
        .rx_byte    (rx_byte)
    );

    i2c_eep_phy u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .op_valid (op_valid),
        .op       (op),
        .tx_byte  (tx_byte),
        .send_nack(send_nack),
        .sda_in   (sda_in),
        .op_done  (op_done),
        .rx_byte  (rx_byte),
        .ack_seen (ack_seen),
        .scl_lo   (scl_pull),
        .sda_lo   (sda_pull),
        .idle     (phy_idle)
    );

    AST_OP_ONLY_WHEN_PHY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) op_valid |-> phy_idle) else $error("op while phy busy"); // R2
    AST_BUS_FREE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && $past(!busy)) |-> (!scl_pull && !sda_pull)) else $error("bus held while idle"); // R10

endmodule

// File: tb/tb_i2c_eeprom_master.sv
module tb_i2c_eeprom_master;
    localparam int DIV  = 4;
    localparam int PMAX = 8;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       cmd_valid, cmd_read;
    logic [3:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic       busy, done, err_nack, err_timeout;
    logic [7:0] rd_data;
    logic       scl_pull, sda_pull;
    logic       slv_lo;
    wire        scl = !scl_pull;
    wire        sda = !(sda_pull || slv_lo);

    i2c_eeprom_master #(.DEV_ADDR(DEV), .ADDR_W(4), .DIV(DIV), .POLL_MAX(PMAX)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .err_nack(err_nack), .err_timeout(err_timeout), .rd_data(rd_data),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- behavioural EEPROM ----------------
    logic [7:0] mem [16];
    logic [7:0] expv [16];
    logic       scl_q, sda_q;
    logic [2:0] mst;
    int         bitc, byte_idx;
    logic [7:0] sh, txs, wdat;
    logic [3:0] ptr;
    logic       rw, wr_pend, bus_free, mack_bit;
    int         busy_cnt;
    int         wbusy_len = 700;
    logic       stuck = 1'b0, nack_addr_mode = 1'b0;
    int         ctrl_w_seen = 0, ctrl_r_seen = 0, bad_ctrl = 0, nacked_ctrl = 0;
    int         rstarts = 0, stops = 0;
    int         hi_cnt = 0, hi_bad = 0, hi_meas = 0;
    logic       hi_valid = 1'b0;
    int         done_cnt = 0;

    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1; sda_q <= 1'b1; mst <= 3'd0; bitc <= 0; byte_idx <= 0;
            slv_lo <= 1'b0; wr_pend <= 1'b0; bus_free <= 1'b1; busy_cnt <= 0;
            ptr <= '0; rw <= 1'b0; mack_bit <= 1'b0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (scl && !scl_q) begin
                hi_cnt <= 1; hi_valid <= 1'b1;
            end else if (scl) begin
                hi_cnt <= hi_cnt + 1;
            end
            if (scl && scl_q && sda_q && !sda) begin
                if (!bus_free) rstarts <= rstarts + 1;
                bus_free <= 1'b0; mst <= 3'd1; bitc <= 0; byte_idx <= 0; hi_valid <= 1'b0;
            end else if (scl && scl_q && !sda_q && sda) begin
                bus_free <= 1'b1; mst <= 3'd0; stops <= stops + 1; slv_lo <= 1'b0; hi_valid <= 1'b0;
                if (wr_pend) begin
                    mem[ptr] <= wdat; busy_cnt <= wbusy_len; wr_pend <= 1'b0;
                end
            end else if (scl && !scl_q) begin
                if (mst == 3'd1) begin
                    sh <= {sh[6:0], sda}; bitc <= bitc + 1;
                end else if (mst == 3'd4) begin
                    mack_bit <= sda; mst <= 3'd0;
                end
            end else if (!scl && scl_q) begin
                if (hi_valid) begin
                    hi_meas <= hi_meas + 1;
                    if (hi_cnt != 2 * DIV) hi_bad <= hi_bad + 1;
                end
                hi_valid <= 1'b0;
                case (mst)
                    3'd1: if (bitc == 8) begin
                        bitc <= 0;
                        byte_idx <= byte_idx + 1;
                        if (byte_idx == 0) begin
                            if (sh[7:1] != DEV) bad_ctrl <= bad_ctrl + 1;
                            if (sh[7:1] == DEV && busy_cnt == 0 && !stuck) begin
                                rw <= sh[0]; slv_lo <= 1'b1; mst <= 3'd2;
                                if (sh[0]) ctrl_r_seen <= ctrl_r_seen + 1;
                                else       ctrl_w_seen <= ctrl_w_seen + 1;
                            end else begin
                                nacked_ctrl <= nacked_ctrl + 1; mst <= 3'd0;
                            end
                        end else if (byte_idx == 1) begin
                            if (nack_addr_mode) mst <= 3'd0;
                            else begin ptr <= sh[3:0]; slv_lo <= 1'b1; mst <= 3'd2; end
                        end else begin
                            wdat <= sh; wr_pend <= 1'b1; slv_lo <= 1'b1; mst <= 3'd2;
                        end
                    end
                    3'd2: begin
                        if (rw) begin
                            mst <= 3'd3; txs <= mem[ptr]; slv_lo <= !mem[ptr][7]; bitc <= 1;
                        end else begin
                            slv_lo <= 1'b0; mst <= 3'd1; bitc <= 0;
                        end
                    end
                    3'd3: begin
                        if (bitc == 8) begin
                            slv_lo <= 1'b0; mst <= 3'd4; ptr <= ptr + 1'b1;
                        end else begin
                            slv_lo <= !txs[7 - bitc]; bitc <= bitc + 1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    logic [7:0] r_data;
    logic       r_en, r_et;

    task automatic run_cmd(input logic rd, input logic [3:0] a, input logic [7:0] d, input int inj);
        int n;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        n = 0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
            if (inj != 0 && n == inj) begin
                cmd_valid = 1'b1; cmd_read = 1'b0; cmd_addr = 4'd5; cmd_wdata = 8'hEE;
            end else begin
                cmd_valid = 1'b0;
            end
            if (done) chk(busy == 1'b1, "R9 busy during done", busy, 1);
        end
        cmd_valid = 1'b0;
        r_data = rd_data; r_en = err_nack; r_et = err_timeout;
        @(negedge clk);
        chk(!done && !busy, "R9 done single cycle then idle", {done, busy}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0, r0, c0, n0, d0;
        for (int i = 0; i < 16; i++) begin mem[i] = 8'hFF; expv[i] = 8'hFF; end
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_addr = '0; cmd_wdata = '0;
        repeat (4) @(negedge clk);
        chk(!scl_pull && !sda_pull && !busy && !done && !err_nack && !err_timeout,
            "R10 outputs in reset", {scl_pull, sda_pull, busy, done, err_nack, err_timeout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_pull && !sda_pull && !busy && !done, "R10 outputs after reset",
            {scl_pull, sda_pull, busy, done}, 0);

        // two exhaustive write/read sweeps
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 16; k++) begin
                int a;
                logic [7:0] v;
                a = (pass == 0) ? k : 15 - k;
                v = (pass == 0) ? 8'((a * 37 + 11) & 255) : 8'(~((a * 19 + 3) & 255));
                n0 = nacked_ctrl; c0 = ctrl_w_seen;
                run_cmd(1'b0, 4'(a), v, 0);
                expv[a] = v;
                chk(!r_en && !r_et, "R4 write error flags", {r_en, r_et}, 0);
                chk(busy_cnt == 0, "R4 device finished before done", busy_cnt, 0);
                chk(mem[a] == v, "R2 device holds written byte", mem[a], v);
                chk(ctrl_w_seen == c0 + 2, "R1 0xA0 acked for write and final probe", ctrl_w_seen - c0, 2);
                if (k == 0) chk(nacked_ctrl > n0, "R4 NACKed polls seen", nacked_ctrl - n0, 1);
            end
            for (int a = 0; a < 16; a++) begin
                r0 = rstarts; s0 = stops; c0 = ctrl_r_seen;
                run_cmd(1'b1, 4'(a), 8'h00, 0);
                chk(r_data == expv[a], "R6 read data", r_data, expv[a]);
                chk(rstarts == r0 + 1, "R6 one repeated start", rstarts - r0, 1);
                chk(ctrl_r_seen == c0 + 1, "R1 0xA1 read control", ctrl_r_seen - c0, 1);
                chk(mack_bit == 1'b1, "R7 master NACKs data byte", mack_bit, 1);
                chk(stops == s0 + 1, "R7 single stop per read", stops - s0, 1);
                chk(!r_en && !r_et, "R6 read error flags", {r_en, r_et}, 0);
            end
        end
        chk(bad_ctrl == 0, "R1 control byte address field", bad_ctrl, 0);

        // command while busy is ignored
        d0 = done_cnt;
        run_cmd(1'b1, 4'd3, 8'h00, 200);
        chk(r_data == expv[3], "R9 read beside ignored command", r_data, expv[3]);
        repeat (2000) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9 one done for one command", done_cnt - d0, 1);
        chk(busy == 1'b0 && mem[5] == expv[5], "R9 ignored write left device", mem[5], expv[5]);
        run_cmd(1'b1, 4'd5, 8'h00, 0);
        chk(r_data == expv[5], "R9 ignored write absent on readback", r_data, expv[5]);

        // NACK on word address: write and read
        nack_addr_mode = 1'b1;
        s0 = stops; n0 = nacked_ctrl;
        run_cmd(1'b0, 4'd7, 8'h99, 0);
        chk(r_en == 1'b1 && r_et == 1'b0, "R8 write address NACK flags", {r_en, r_et}, 2);
        chk(stops == s0 + 1 && nacked_ctrl == n0, "R8 one stop, no poll", stops - s0, 1);
        chk(mem[7] == expv[7], "R8 nothing written", mem[7], expv[7]);
        run_cmd(1'b1, 4'd7, 8'h00, 0);
        chk(r_en == 1'b1 && r_et == 1'b0, "R8 read address NACK flags", {r_en, r_et}, 2);
        nack_addr_mode = 1'b0;

        // device never answers: timeout at command start
        stuck = 1'b1;
        n0 = nacked_ctrl;
        run_cmd(1'b1, 4'd2, 8'h00, 0);
        chk(r_et == 1'b1 && r_en == 1'b0, "R5 start timeout flags", {r_en, r_et}, 1);
        chk(nacked_ctrl - n0 == PMAX, "R3 attempts at start", nacked_ctrl - n0, PMAX);

        // device answers after a few refusals: retry recovers
        n0 = nacked_ctrl;
        fork
            run_cmd(1'b1, 4'd2, 8'h00, 0);
            begin repeat (450) @(negedge clk); stuck = 1'b0; end
        join
        chk(nacked_ctrl > n0, "R3 some control bytes refused", nacked_ctrl - n0, 1);
        chk(!r_en && !r_et && r_data == expv[2], "R3 read after retry", r_data, expv[2]);

        // write cycle longer than the poll budget
        wbusy_len = 4000;
        n0 = nacked_ctrl;
        run_cmd(1'b0, 4'd9, 8'h3C, 0);
        expv[9] = 8'h3C;
        chk(r_et == 1'b1 && r_en == 1'b0, "R5 poll timeout flags", {r_en, r_et}, 1);
        chk(nacked_ctrl - n0 == PMAX, "R5 poll attempts", nacked_ctrl - n0, PMAX);
        wbusy_len = 700;
        repeat (4200) @(negedge clk);
        run_cmd(1'b1, 4'd9, 8'h00, 0);
        chk(r_data == 8'h3C, "R2 byte stored despite poll timeout", r_data, 8'h3C);

        chk(hi_meas > 0 && hi_bad == 0, "R11 SCL high width", hi_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule